// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block holds the time of day and the calendar date in seven byte-wide fields: second, minute, hour (24-hour only), weekday, day of month, month and a two-digit year. One accepted tick strobe adds one second and carries as far up the chain as needed. The carry goes from seconds to minutes to hours, then to day and weekday together, then to month and year. The day wraps at the length of the current month, and February takes its leap-year length from the windowed year.

A data-mode input picks how the fields appear on the outputs and how values on the load port are read. Packed BCD puts the tens digit in bits 7:4 and the units digit in bits 3:0. Plain binary holds the value directly. A load port lets software write any single field. A freeze input holds the time while software rewrites it.

The year register keeps only two digits. Codes 50 to 99 stand for 1950 to 1999 and codes 00 to 49 stand for 2000 to 2049. Both centuries are multiples of four, so the leap test depends only on the two stored digits.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read 00:00:00 for hour, minute and second, with weekday 7, day 01, month 01 and year 00.
- R2: With bin_mode_i = 0, every output field and the load data are packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. With bin_mode_i = 1 they are plain binary. Changing bin_mode_i only changes how the held time is shown and does not change the time itself.
- R3: A tick is accepted when tick_i is 1, freeze_i is 0 and load_we_i is 0 at a rising clock edge. Each accepted tick adds exactly one second, and the new value appears on the outputs after that edge.
- R4: Second 59 wraps to 00 and adds one minute. Minute 59 wraps to 00 and adds one hour. Hour 23 wraps to 00 and advances the day.
- R5: April, June, September and November have 30 days. January, March, May, July, August, October and December have 31 days. When the day passes the end of its month, it becomes 01 and the month goes up by one. Month 12 wraps to 01 and adds one year. Year 99 wraps to 00.
- R6: February has 29 days when the two-digit year modulo 4 is 0, and 28 days otherwise. Year 00 (2000) and year 96 are leap years. Years 50 and 99 are not.
- R7: Weekday runs from 1 to 7, where 1 means Sunday. It goes up by one each time the day advances, and 7 wraps to 1.
- R8: While freeze_i is 1, tick_i has no effect, and every field holds its value.
- R9: When load_we_i is 1, load_data_i is written into the field chosen by load_sel_i, and the new value appears after the edge. The select codes are 0 second, 1 minute, 2 hour, 3 weekday, 4 day, 5 month and 6 year. Code 7 writes no field.
- R10: A tick in a cycle where load_we_i is 1 is dropped. The selected field takes the load value, and every other field keeps its value.
- R11: A field loaded with a value at or above its top value wraps to its lowest value on the next increment, and it carries into the next field as if it had rolled over normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-second advance strobe |
| freeze_i | input | 1 | Holds the time; ticks are ignored while high |
| bin_mode_i | input | 1 | Encoding select: 0 packed BCD, 1 binary |
| load_we_i | input | 1 | Field write strobe |
| load_sel_i | input | 3 | Field select for a write |
| load_data_i | input | 8 | Write value, in the selected encoding |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours, 24-hour format |
| wday_o | output | 8 | Weekday, 1 = Sunday |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
The bench targets the rollovers at the top of the carry chain. It starts at 23:59:59 on December 31 of year 99 and expects 00:00:00 on January 1 of year 00. A broken carry would leave the year or month stuck, or would make hour 24 or month 13 appear. It checks February 28 in years 00, 96, 99 and 50, plus the 30-day month ends. A wrong leap test would put a February 29 in 1999 or 1950, or would skip it in 2000. A wrong month length would jump straight from April 30 to May 2 or show April 31. It also covers a tick in the same cycle as a write, a frozen clock, select code 7 and a second loaded out of range. A design that got these wrong would advance the second alongside the write, would keep counting while frozen, would corrupt a field from code 7, or would stop counting at the stuck value.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NFLD = 7;
  localparam int FW   = 7;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_WDAY = 3'd3,
    F_MDAY = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6,
    F_NONE = 3'd7
  } fld_e;

  function automatic logic [FW-1:0] fld_lo(input int idx);
    if (idx == int'(F_WDAY) || idx == int'(F_MDAY) || idx == int'(F_MON))
      return FW'(1);
    return FW'(0);
  endfunction

  function automatic logic [FW-1:0] fld_rst(input int idx);
    if (idx == int'(F_WDAY)) return FW'(7);
    return fld_lo(idx);
  endfunction

  function automatic logic [FW-1:0] fld_top(input int idx);
    case (idx)
      int'(F_SEC), int'(F_MIN): return FW'(59);
      int'(F_HOUR):             return FW'(23);
      int'(F_WDAY):             return FW'(7);
      int'(F_MDAY):             return FW'(31);
      int'(F_MON):              return FW'(12);
      default:                  return FW'(99);
    endcase
  endfunction

  function automatic logic [FW-1:0] bcd_to_bin(input logic [7:0] b);
    return FW'(b[7:4]) * FW'(10) + FW'(b[3:0]);
  endfunction

  function automatic logic [7:0] bin_to_bcd(input logic [FW-1:0] v);
    logic [7:0] r;
    r[7:4] = 4'(v / FW'(10));
    r[3:0] = 4'(v % FW'(10));
    return r;
  endfunction
endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/cal_field_ctr.sv
module cal_field_ctr #(
  parameter int           W    = 7,
  parameter logic [W-1:0] LO   = '0,
  parameter logic [W-1:0] RSTV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;
  logic         val_en;

  always_comb begin
    val_en = ld_i | inc_i;
    val_d  = val_q;
    if (ld_i)              val_d = ld_val_i;
    else if (inc_i) begin
      if (val_q >= top_i)  val_d = LO;
      else                 val_d = val_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= RSTV;
    else if (val_en) val_q <= val_d;
  end

  assign val_o = val_q;
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len #(
  parameter int W = 7
) (
  input  logic [W-1:0] mon_i,
  input  logic [W-1:0] year_i,
  output logic [W-1:0] last_day_o
);
  logic leap;

  // Both 19xx and 20xx bases are multiples of four, so two bits decide.
  assign leap = (year_i[1:0] == 2'b00);

  always_comb begin
    case (mon_i)
      W'(2):                       last_day_o = leap ? W'(29) : W'(28);
      W'(4), W'(6), W'(9), W'(11): last_day_o = W'(30);
      default:                     last_day_o = W'(31);
    endcase
  end
endmodule

// File: rtl/cal_enc.sv
module cal_enc #(
  parameter int W = 7
) (
  input  logic         bin_mode_i,
  input  logic [W-1:0] val_i,
  output logic [7:0]   enc_o
);
  import cal_pkg::*;

  always_comb begin
    if (bin_mode_i) enc_o = 8'(val_i);
    else            enc_o = bin_to_bcd(val_i);
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       freeze_i,
  input  logic       bin_mode_i,
  input  logic       load_we_i,
  input  logic [2:0] load_sel_i,
  input  logic [7:0] load_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o
);
  import cal_pkg::*;

  logic                          rst_q_n;
  logic                          tick_ok;
  logic [FW-1:0]                 ld_val;
  logic [FW-1:0]                 mday_last;
  logic [NFLD-1:0]               fld_ld;
  logic [NFLD-1:0]               fld_inc;
  logic [NFLD-1:0]               at_top;
  logic [NFLD-1:0][FW-1:0]       fld_top_v;
  logic [NFLD-1:0][FW-1:0]       fld_val;
  logic [NFLD-1:0][7:0]          fld_enc;

  cal_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cal_month_len #(.W(FW)) u_mlen (
    .mon_i      (fld_val[F_MON]),
    .year_i     (fld_val[F_YEAR]),
    .last_day_o (mday_last)
  );

  // A write in the same cycle wins over the tick: the tick is dropped.
  assign tick_ok = tick_i & ~freeze_i & ~load_we_i;
  assign ld_val  = bin_mode_i ? load_data_i[FW-1:0] : bcd_to_bin(load_data_i);

  // Carry chain: each enable depends only on registered values.
  always_comb begin
    fld_inc          = '0;
    fld_inc[F_SEC]   = tick_ok;
    fld_inc[F_MIN]   = fld_inc[F_SEC]  & at_top[F_SEC];
    fld_inc[F_HOUR]  = fld_inc[F_MIN]  & at_top[F_MIN];
    fld_inc[F_WDAY]  = fld_inc[F_HOUR] & at_top[F_HOUR];
    fld_inc[F_MDAY]  = fld_inc[F_HOUR] & at_top[F_HOUR];
    fld_inc[F_MON]   = fld_inc[F_MDAY] & at_top[F_MDAY];
    fld_inc[F_YEAR]  = fld_inc[F_MON]  & at_top[F_MON];
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    if (g == int'(F_MDAY)) begin : g_dyn
      assign fld_top_v[g] = mday_last;
    end else begin : g_fix
      assign fld_top_v[g] = fld_top(g);
    end

    assign fld_ld[g] = load_we_i & (load_sel_i == 3'(g));
    assign at_top[g] = (fld_val[g] >= fld_top_v[g]);

    cal_field_ctr #(
      .W    (FW),
      .LO   (fld_lo(g)),
      .RSTV (fld_rst(g))
    ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .ld_i     (fld_ld[g]),
      .ld_val_i (ld_val),
      .inc_i    (fld_inc[g]),
      .top_i    (fld_top_v[g]),
      .val_o    (fld_val[g])
    );

    cal_enc #(.W(FW)) u_enc (
      .bin_mode_i (bin_mode_i),
      .val_i      (fld_val[g]),
      .enc_o      (fld_enc[g])
    );
  end

  assign sec_o  = fld_enc[F_SEC];
  assign min_o  = fld_enc[F_MIN];
  assign hour_o = fld_enc[F_HOUR];
  assign wday_o = fld_enc[F_WDAY];
  assign mday_o = fld_enc[F_MDAY];
  assign mon_o  = fld_enc[F_MON];
  assign year_o = fld_enc[F_YEAR];
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_i,
  input logic                  freeze_i,
  input logic                  bin_mode_i,
  input logic                  load_we_i,
  input logic [2:0]            load_sel_i,
  input logic [7:0]            load_data_i,
  input logic [6:0][6:0]       fld_val,
  input logic [7:0]            sec_o,
  input logic [7:0]            min_o,
  input logic [7:0]            hour_o
);
  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !load_we_i) |=> $stable(fld_val));

  a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !freeze_i && !load_we_i && fld_val[0] < 7'd59)
      |=> (fld_val[0] == $past(fld_val[0]) + 7'd1));

  a_r9_year_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_we_i && load_sel_i == 3'd6 && bin_mode_i)
      |=> (fld_val[6] == $past(load_data_i[6:0])));

  a_r10_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (load_we_i && load_sel_i != 3'd0) |=> $stable(fld_val[0]));

  a_r7_wday_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !freeze_i && !load_we_i && fld_val[0] >= 7'd59 &&
     fld_val[1] >= 7'd59 && fld_val[2] >= 7'd23) |=> !$stable(fld_val[3]));

  a_r2_bcd_units: assert property (@(posedge clk) disable iff (!rst_n)
    !bin_mode_i |-> (sec_o[3:0] <= 4'd9 && min_o[3:0] <= 4'd9 && hour_o[3:0] <= 4'd9));
endmodule

bind bcd_calendar cal_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .tick_i      (tick_i),
  .freeze_i    (freeze_i),
  .bin_mode_i  (bin_mode_i),
  .load_we_i   (load_we_i),
  .load_sel_i  (load_sel_i),
  .load_data_i (load_data_i),
  .fld_val     (fld_val),
  .sec_o       (sec_o),
  .min_o       (min_o),
  .hour_o      (hour_o)
);

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;
  logic       clk;
  logic       rst_n;
  logic       tick_i;
  logic       freeze_i;
  logic       bin_mode_i;
  logic       load_we_i;
  logic [2:0] load_sel_i;
  logic [7:0] load_data_i;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;

  bcd_calendar dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
    .bin_mode_i(bin_mode_i), .load_we_i(load_we_i), .load_sel_i(load_sel_i),
    .load_data_i(load_data_i), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    load_we_i = 1'b1; load_sel_i = sel; load_data_i = data;
    cyc();
    load_we_i = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] yr, mo, md, wd, hr, mi, se);
    wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, md); wr(3'd3, wd);
    wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      cyc();
    end
    tick_i = 1'b0;
  endtask

  task automatic chk_all(input string tag, input logic [7:0] yr, mo, md, wd, hr, mi, se);
    chk({tag, " year"}, year_o, yr);
    chk({tag, " month"}, mon_o, mo);
    chk({tag, " day"}, mday_o, md);
    chk({tag, " wday"}, wday_o, wd);
    chk({tag, " hour"}, hour_o, hr);
    chk({tag, " min"}, min_o, mi);
    chk({tag, " sec"}, sec_o, se);
  endtask

  task automatic t_reset();
    chk_all("R1 reset", 8'h00, 8'h01, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_seconds();
    ticks(3);
    chk("R3 three ticks", sec_o, 8'h03);
    ticks(10);
    chk("R3 BCD tens", sec_o, 8'h13);
    set_time(8'h10, 8'h06, 8'h15, 8'h02, 8'h05, 8'h14, 8'h59);
    ticks(1);
    chk_all("R4 minute carry", 8'h10, 8'h06, 8'h15, 8'h02, 8'h05, 8'h15, 8'h00);
  endtask

  task automatic t_year_wrap();
    set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk_all("R5 R4 year wrap", 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_wday_wrap();
    set_time(8'h20, 8'h03, 8'h07, 8'h07, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R7 wday 7 to 1", wday_o, 8'h01);
    chk("R7 day advance", mday_o, 8'h08);
  endtask

  task automatic t_leap();
    set_time(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R6 2000 feb 29 day", mday_o, 8'h29);
    chk("R6 2000 feb 29 mon", mon_o, 8'h02);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    ticks(1);
    chk("R6 2000 mar 1 day", mday_o, 8'h01);
    chk("R6 2000 mar 1 mon", mon_o, 8'h03);
    set_time(8'h96, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R6 1996 feb 29", mday_o, 8'h29);
    set_time(8'h99, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R6 1999 day", mday_o, 8'h01);
    chk("R6 1999 mon", mon_o, 8'h03);
    set_time(8'h50, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R6 1950 day", mday_o, 8'h01);
    chk("R6 1950 mon", mon_o, 8'h03);
  endtask

  task automatic t_month_len();
    set_time(8'h01, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R5 apr 30 day", mday_o, 8'h01);
    chk("R5 apr 30 mon", mon_o, 8'h05);
    set_time(8'h01, 8'h01, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R5 jan 31", mday_o, 8'h31);
    chk("R5 jan stays", mon_o, 8'h01);
  endtask

  task automatic t_freeze();
    set_time(8'h05, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05);
    freeze_i = 1'b1;
    ticks(5);
    chk("R8 frozen sec", sec_o, 8'h05);
    freeze_i = 1'b0;
    ticks(1);
    chk("R8 thawed sec", sec_o, 8'h06);
  endtask

  task automatic t_prio();
    set_time(8'h07, 8'h07, 8'h07, 8'h04, 8'h07, 8'h07, 8'h10);
    tick_i = 1'b1;
    wr(3'd1, 8'h33);
    tick_i = 1'b0;
    chk("R10 tick dropped sec", sec_o, 8'h10);
    chk("R10 load wins min", min_o, 8'h33);
    chk("R10 hour kept", hour_o, 8'h07);
  endtask

  task automatic t_sel7();
    set_time(8'h11, 8'h11, 8'h11, 8'h03, 8'h11, 8'h11, 8'h11);
    wr(3'd7, 8'h55);
    chk_all("R9 code 7", 8'h11, 8'h11, 8'h11, 8'h03, 8'h11, 8'h11, 8'h11);
  endtask

  task automatic t_binary();
    bin_mode_i = 1'b1;
    wr(3'd0, 8'd45);
    chk("R2 binary sec", sec_o, 8'd45);
    chk("R2 binary hour", hour_o, 8'd11);
    bin_mode_i = 1'b0;
    #1;
    chk("R2 back to BCD", sec_o, 8'h45);
  endtask

  task automatic t_range();
    bin_mode_i = 1'b1;
    wr(3'd1, 8'd20);
    wr(3'd0, 8'd75);
    ticks(1);
    chk("R11 sec wraps", sec_o, 8'd0);
    chk("R11 min carry", min_o, 8'd21);
    bin_mode_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; freeze_i = 1'b0; bin_mode_i = 1'b0;
    load_we_i = 1'b0; load_sel_i = 3'd0; load_data_i = 8'h00;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();
    t_reset();
    t_seconds();
    t_year_wrap();
    t_wday_wrap();
    t_leap();
    t_month_len();
    t_freeze();
    t_prio();
    t_sel7();
    t_binary();
    t_range();
    finish_run();
  end
endmodule